// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration image into a target programmable device over a passive serial link. A single start pulse launches a complete load. The block first pulses the target's active-low configuration request line, high then low then high. It then waits for the target's active-low status line to report that it is ready. Next it shifts the image out one bit per serial clock pulse. It keeps clocking until the target reports that configuration is complete, and finally issues a fixed run of trailing clocks so the target can enter user mode.

Image bytes arrive on a valid/ready byte stream, and a last-byte marker ends the image. After the marked byte the block appends two zero bytes on its own. Both waits on the target are bounded. If either wait runs out, the block raises a sticky error, parks the request line high and returns to idle. The serial clock rate and the length of each request phase are set by two configuration inputs. The block also exposes a three-bit handshake word that shows the request line and the two synchronized target inputs.

Top module: `pscfg_seq`

## Requirements
- R1: A `start_i` pulse while idle begins a load. On the next clock `busy_o` is 1 and `done_o` and `error_o` are both cleared. A `start_i` pulse while busy has no effect on the load in progress.
- R2: One tick lasts `cfg_div_i`+1 clocks. The request line stays high for `cfg_hold_i`+1 ticks after start, then low for `cfg_hold_i`+1 ticks, then high for `cfg_hold_i`+1 ticks before the ready wait. It therefore falls 1+(`cfg_hold_i`+1)(`cfg_div_i`+1) clocks after the clock edge that samples start. No serial clock pulse occurs while the line is low.
- R3: In the ready wait the synchronized status input is tested once per tick. After 15625 tests that read low, the block sets the error flag and returns to idle without issuing any serial clock pulse. With `cfg_div_i`=0 and `cfg_hold_i`=0, `busy_o` drops 15629 clocks after the start edge.
- R4: Each byte is sent as 8 bits, least significant bit first. Each bit takes one low tick followed by one high tick of `dclk_o`. `data_o` is set while `dclk_o` is low and stays unchanged while `dclk_o` is high.
- R5: After the byte marked last, exactly two all-zero bytes are shifted out.
- R6: After the padding, `dclk_o` keeps pulsing with `data_o`=0. Before each pulse the synchronized done input is tested. If 15625 such pulses pass without done reading high, the error flag is set and the load ends.
- R7: When done reads high, exactly 10 more pulses with `data_o`=0 follow. `done_o` is then set, stays set until the next start, and `busy_o` drops.
- R8: `hs_word_o` bit 0 is the request line level (value 0x01). Bit 1 is the done input (0x02). Bit 2 is the active-low status input (0x04). Bits 1 and 2 pass through two flip-flop stages, so an input change shows up after the second rising clock edge.
- R9: `s_ready_o` is 1 only in the shift phase, when the shifter is empty and the last byte has not yet been taken. It is never 1 while `dclk_o` is high. Exactly one byte is taken per handshake.
- R10: On an error the request line is high, the block is idle, and `error_o` stays set until the next start. `done_o` and `error_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a load |
| cfg_div_i | input | DIV_W | Tick length minus one, in clocks |
| cfg_hold_i | input | HOLD_W | Request phase length minus one, in ticks |
| s_data_i | input | BYTE_W | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Block takes the byte this cycle |
| n_status_i | input | 1 | Target active-low status |
| conf_done_i | input | 1 | Target configuration complete |
| n_cfg_o | output | 1 | Active-low configuration request to target |
| dclk_o | output | 1 | Serial clock to target |
| data_o | output | 1 | Serial data to target |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load finished successfully (sticky) |
| error_o | output | 1 | Last load timed out (sticky) |
| hs_word_o | output | 3 | Handshake word: request, done, status |

## Verification
The request line is due to fall exactly 1+(hold+1)(div+1) clocks after the clock edge that samples start, and it stays low for (hold+1)(div+1) clocks. The bench counts negative edges from start and compares both figures. A status timeout with unit ticks must end at clock 15629. The two synchronized bits of the handshake word are checked one edge and two edges after an input change. When done is raised late, it is raised right after a chosen serial pulse, and only with a tick of at least three clocks; in that case the synchronizer settles before the next low-phase test, and the total number of pulses is exact.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_A,
    ST_REQ_LOW,
    ST_REQ_B,
    ST_READY_WAIT,
    ST_SHIFT,
    ST_FLUSH,
    ST_TRAIL
  } seq_state_e;

  // handshake word bit positions (fixed, decoded by software)
  localparam int HS_REQ  = 0;
  localparam int HS_DONE = 1;
  localparam int HS_STAT = 2;

endpackage

// File: rtl/pscfg_tick.sv
module pscfg_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = cnt_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pscfg_serdrv.sv
module pscfg_serdrv #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              rise,
  input  logic              fall,
  output logic              dclk,
  output logic              dout,
  output logic              empty
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              dclk_q, dclk_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    dclk_d = dclk_q;
    if (clr) begin
      sh_d   = '0;
      left_d = '0;
      dclk_d = 1'b0;
    end else begin
      if (load) begin
        sh_d   = load_byte;
        left_d = CNT_W'(BYTE_W);
      end
      if (rise) begin
        dclk_d = 1'b1;
      end
      if (fall) begin
        dclk_d = 1'b0;
        if (left_q != '0) begin
          sh_d   = {1'b0, sh_q[BYTE_W-1:1]};
          left_d = left_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      dclk_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      dclk_q <= dclk_d;
    end
  end

  assign dclk  = dclk_q;
  assign dout  = sh_q[0];
  assign empty = (left_q == '0);

endmodule

// File: rtl/pscfg_seq.sv
module pscfg_seq
  import pscfg_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int HOLD_W      = 8,
  parameter int BYTE_W      = 8,
  parameter int STAT_WAIT   = 15625,
  parameter int DONE_WAIT   = 15625,
  parameter int TRAIL_CLKS  = 10,
  parameter int PAD_BYTES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [HOLD_W-1:0] cfg_hold_i,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic              n_status_i,
  input  logic              conf_done_i,
  output logic              n_cfg_o,
  output logic              dclk_o,
  output logic              data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [2:0]        hs_word_o
);

  localparam int WCNT_W = $clog2(STAT_WAIT);
  localparam int PCNT_W = $clog2(DONE_WAIT + 1);
  localparam int TCNT_W = $clog2(TRAIL_CLKS + 1);
  localparam int PAD_W  = $clog2(PAD_BYTES + 1);
  localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(STAT_WAIT - 1);
  localparam logic [PCNT_W-1:0] PULSE_MAX = PCNT_W'(DONE_WAIT);
  localparam logic [TCNT_W-1:0] TRAIL_MAX = TCNT_W'(TRAIL_CLKS);
  localparam logic [PAD_W-1:0]  PAD_INIT  = PAD_W'(PAD_BYTES);

  seq_state_e        state_q, state_d;
  logic [HOLD_W-1:0] dcnt_q, dcnt_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [PAD_W-1:0]  pads_q, pads_d;
  logic              last_q, last_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              ncfg_q, ncfg_d;

  logic              run, tick, hold_end, low_tick;
  logic              sh_clr, sh_load, sh_rise, sh_fall, sh_empty;
  logic [BYTE_W-1:0] sh_byte;
  logic [1:0]        sync_q;
  logic              nst_s, cd_s;

  assign run = (state_q != ST_IDLE);

  pscfg_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (cfg_div_i),
    .tick (tick)
  );

  pscfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({n_status_i, conf_done_i}),
    .q    (sync_q)
  );

  assign nst_s = sync_q[1];
  assign cd_s  = sync_q[0];

  pscfg_serdrv #(.BYTE_W(BYTE_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sh_clr),
    .load     (sh_load),
    .load_byte(sh_byte),
    .rise     (sh_rise),
    .fall     (sh_fall),
    .dclk     (dclk_o),
    .dout     (data_o),
    .empty    (sh_empty)
  );

  assign hold_end = tick && (dcnt_q == cfg_hold_i);
  assign low_tick = tick && !dclk_o;
  assign sh_fall  = tick && dclk_o;

  // next-state logic
  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    wcnt_d  = wcnt_q;
    pcnt_d  = pcnt_q;
    tcnt_d  = tcnt_q;
    pads_d  = pads_q;
    last_d  = last_q;
    done_d  = done_q;
    err_d   = err_q;
    sh_clr  = 1'b0;
    sh_load = 1'b0;
    sh_byte = s_data_i;
    sh_rise = 1'b0;
    if (tick && !hold_end) begin
      dcnt_d = dcnt_q + 1'b1;
    end
    unique case (state_q)
      ST_IDLE: begin
        sh_clr = 1'b1;
        dcnt_d = '0;
        if (start_i) begin
          state_d = ST_REQ_A;
          done_d  = 1'b0;
          err_d   = 1'b0;
        end
      end
      ST_REQ_A: begin
        if (hold_end) begin
          state_d = ST_REQ_LOW;
          dcnt_d  = '0;
        end
      end
      ST_REQ_LOW: begin
        if (hold_end) begin
          state_d = ST_REQ_B;
          dcnt_d  = '0;
        end
      end
      ST_REQ_B: begin
        if (hold_end) begin
          state_d = ST_READY_WAIT;
          dcnt_d  = '0;
          wcnt_d  = '0;
        end
      end
      ST_READY_WAIT: begin
        if (tick) begin
          if (nst_s) begin
            state_d = ST_SHIFT;
            last_d  = 1'b0;
            pads_d  = PAD_INIT;
          end else if (wcnt_q == WAIT_LAST) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      ST_SHIFT: begin
        if (sh_empty) begin
          if (!last_q) begin
            if (s_valid_i) begin
              sh_load = 1'b1;
              last_d  = s_last_i;
            end
          end else if (pads_q != '0) begin
            sh_load = 1'b1;
            sh_byte = '0;
            pads_d  = pads_q - 1'b1;
          end else begin
            state_d = ST_FLUSH;
            pcnt_d  = '0;
          end
        end else if (low_tick) begin
          sh_rise = 1'b1;
        end
      end
      ST_FLUSH: begin
        if (low_tick) begin
          if (cd_s) begin
            state_d = ST_TRAIL;
            tcnt_d  = '0;
          end else if (pcnt_q == PULSE_MAX) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
          end else begin
            sh_rise = 1'b1;
            pcnt_d  = pcnt_q + 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (low_tick) begin
          if (tcnt_q == TRAIL_MAX) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            sh_rise = 1'b1;
            tcnt_d  = tcnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    ncfg_d = (state_d != ST_REQ_LOW);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      wcnt_q  <= '0;
      pcnt_q  <= '0;
      tcnt_q  <= '0;
      pads_q  <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ncfg_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
      wcnt_q  <= wcnt_d;
      pcnt_q  <= pcnt_d;
      tcnt_q  <= tcnt_d;
      pads_q  <= pads_d;
      last_q  <= last_d;
      done_q  <= done_d;
      err_q   <= err_d;
      ncfg_q  <= ncfg_d;
    end
  end

  assign s_ready_o = (state_q == ST_SHIFT) && sh_empty && !last_q;
  assign n_cfg_o   = ncfg_q;
  assign busy_o    = run;
  assign done_o    = done_q;
  assign error_o   = err_q;

  always_comb begin
    hs_word_o          = '0;
    hs_word_o[HS_REQ]  = ncfg_q;
    hs_word_o[HS_DONE] = cd_s;
    hs_word_o[HS_STAT] = nst_s;
  end

endmodule

// File: rtl/pscfg_seq_chk.sv
module pscfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic s_ready_o,
  input logic n_cfg_o,
  input logic dclk_o,
  input logic data_o,
  input logic busy_o,
  input logic done_o,
  input logic error_o
);

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o && !error_o));

  assert_no_clk_req_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !n_cfg_o |-> !dclk_o);

  assert_data_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o && $past(dclk_o)) |-> $stable(data_o));

  assert_no_clk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !dclk_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_ready_low_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_o |-> !s_ready_o);

  assert_err_req_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (n_cfg_o && !busy_o));

  assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));

endmodule

bind pscfg_seq pscfg_seq_chk u_chk (.*);

// File: tb/tb_pscfg_seq.sv
`timescale 1ns/1ps
module tb_pscfg_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] cfg_div_i = '0;
  logic [7:0] cfg_hold_i = '0;
  logic [7:0] s_data_i = '0;
  logic       s_valid_i = 1'b0;
  logic       s_last_i = 1'b0;
  logic       s_ready_o;
  logic       n_status_i;
  logic       conf_done_i = 1'b0;
  logic       n_cfg_o, dclk_o, data_o, busy_o, done_o, error_o;
  logic [2:0] hs_word_o;
  logic       st_follow = 1'b1;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_mem [0:63];
  int  r_low, r_tfall, r_rises, r_mism, r_end, acc_cnt;
  bit  active;

  always #2 clk = ~clk;

  // target model: status follows the request line when healthy
  assign n_status_i = st_follow ? n_cfg_o : 1'b0;

  pscfg_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cfg_div_i(cfg_div_i), .cfg_hold_i(cfg_hold_i),
    .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_last_i(s_last_i),
    .s_ready_o(s_ready_o), .n_status_i(n_status_i), .conf_done_i(conf_done_i),
    .n_cfg_o(n_cfg_o), .dclk_o(dclk_o), .data_o(data_o),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .hs_word_o(hs_word_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic feed(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid_i = 1'b1;
      s_data_i  = exp_mem[i];
      s_last_i  = (i == n - 1);
      while (active && !s_ready_o) @(negedge clk);
      if (!active) break;
      acc_cnt++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        s_valid_i = 1'b0;
      end
    end
    @(negedge clk);
    s_valid_i = 1'b0;
    s_last_i  = 1'b0;
  endtask

  // f_raise: -1 done high from the start, -2 never, >=0 raise after that many flush pulses
  task automatic run_load(input int d, input int h, input int n, input int gap,
                          input int f_raise, input bit st_ok, input bit poke);
    int  cyc;
    int  k;
    bit  prev;
    bit  e;
    cfg_div_i   = 8'(d);
    cfg_hold_i  = 8'(h);
    st_follow   = st_ok;
    conf_done_i = (f_raise == -1);
    for (int i = 0; i < n; i++) exp_mem[i] = 8'((i * 53 + d * 29 + h * 7 + 5) & 255);
    acc_cnt = 0; r_low = 0; r_tfall = -1; r_rises = 0; r_mism = 0; r_end = 0;
    active = 1'b1;
    @(negedge clk);
    start_i = 1'b1;
    fork
      begin
        cyc  = 0;
        prev = 1'b0;
        while (1) begin
          @(negedge clk);
          cyc++;
          start_i = poke && (cyc == 40);
          if (cyc == 1)
            chk(busy_o && !done_o && !error_o, "R1 R10 start clears flags, busy", int'(busy_o), 1);
          if (!n_cfg_o) begin
            r_low++;
            if (r_tfall < 0) r_tfall = cyc;
          end
          if (dclk_o && !prev) begin
            k = r_rises;
            e = (k / 8 < n) ? exp_mem[k / 8][k % 8] : 1'b0;
            if (data_o !== e) r_mism++;
            r_rises++;
            if (f_raise >= 0 && r_rises == 8 * (n + 2) + f_raise) conf_done_i = 1'b1;
          end
          prev = dclk_o;
          if (!busy_o && cyc > 1) break;
        end
        r_end  = cyc;
        active = 1'b0;
      end
      feed(n, gap);
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(n_cfg_o == 1'b1, "R10 reset request line high", int'(n_cfg_o), 1);
    chk(!dclk_o && !data_o, "R4 reset serial outputs low", int'(dclk_o), 0);
    chk(!busy_o && !done_o && !error_o, "R1 reset flags", int'({busy_o, done_o, error_o}), 0);
    chk(!s_ready_o, "R9 reset ready low", int'(s_ready_o), 0);
    repeat (3) @(negedge clk);
    chk(hs_word_o == 3'b101, "R8 idle handshake word", int'(hs_word_o), 5);
    conf_done_i = 1'b1;
    @(negedge clk);
    chk(hs_word_o[1] == 1'b0, "R8 done bit after one edge", int'(hs_word_o[1]), 0);
    @(negedge clk);
    chk(hs_word_o[1] == 1'b1, "R8 done bit after two edges", int'(hs_word_o[1]), 1);

    // sweep of divider and hold settings
    for (int d = 0; d < 4; d++) begin
      for (int h = 0; h < 4; h++) begin
        int n;
        int gap;
        int f;
        int fl;
        n   = 1 + ((d * 4 + h) % 5);
        gap = (d + h) % 3;
        f   = (d >= 2 && (h % 2) == 1) ? (h + d) : -1;
        fl  = (f < 0) ? 0 : f;
        run_load(d, h, n, gap, f, 1'b1, (d == 0 && h == 0));
        chk(r_tfall == 1 + (h + 1) * (d + 1), "R2 request fall time", r_tfall, 1 + (h + 1) * (d + 1));
        chk(r_low == (h + 1) * (d + 1), "R2 request low length", r_low, (h + 1) * (d + 1));
        chk(r_mism == 0, "R4 R5 serial bits, LSB first, zero padding", r_mism, 0);
        chk(r_rises == 8 * (n + 2) + fl + 10, "R5 R6 R7 pulse count", r_rises, 8 * (n + 2) + fl + 10);
        chk(acc_cnt == n, "R9 bytes taken", acc_cnt, n);
        chk(done_o && !error_o && !busy_o, "R7 done after trailing pulses", int'({done_o, error_o}), 2);
      end
    end

    // status never ready
    run_load(0, 0, 2, 0, -2, 1'b0, 1'b0);
    chk(r_rises == 0, "R3 no pulses on status timeout", r_rises, 0);
    chk(r_end == 15629, "R3 status timeout length", r_end, 15629);
    chk(error_o && !done_o, "R3 R10 error set", int'({done_o, error_o}), 1);
    chk(n_cfg_o == 1'b1, "R10 request high after error", int'(n_cfg_o), 1);
    chk(hs_word_o == 3'b001, "R8 handshake word with both inputs low", int'(hs_word_o), 1);
    repeat (5) @(negedge clk);
    chk(error_o == 1'b1, "R10 error sticky while idle", int'(error_o), 1);

    // recovery after error
    run_load(1, 1, 3, 1, -1, 1'b1, 1'b0);
    chk(r_mism == 0 && r_rises == 8 * 5 + 10, "R1 R10 load after error", r_rises, 50);
    chk(done_o && !error_o, "R7 done after recovery", int'({done_o, error_o}), 2);

    // done never arrives
    run_load(0, 0, 1, 0, -2, 1'b1, 1'b0);
    chk(r_rises == 8 * 3 + 15625, "R6 flush timeout pulse count", r_rises, 8 * 3 + 15625);
    chk(r_mism == 0, "R6 flush data zero", r_mism, 0);
    chk(error_o && !done_o && n_cfg_o, "R6 R10 flush timeout error", int'({done_o, error_o}), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

endmodule